// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

This block is a clocked static memory with a two-bit burst address counter. A burst may be opened by either of two start strobes: a processor strobe or a controller strobe. Once open, the burst steps through a four-word group in linear or interleaved order under an advance input. It can also hold on its current word, or be closed by deselection. Every control, address and write-data input is sampled on the rising clock edge. Writes go into the selected byte lanes of an internal array during the cycle they are sampled. Read data is registered and appears in the cycle after the access is sampled.

Each lane is `LANE_W` bits wide. With the default of 9, the ninth bit of a lane is a parity bit: it is stored and returned together with the eight data bits and is never computed. The bidirectional data bus is split into `dq_in`, `dq_out` and the pad enable `dq_oe`, and the three-state driver sits in the pad ring. `dq_oe` follows the output-enable input without a register. The bus has no back-pressure: a new command is taken every cycle unless the block is snoozing or waking.

A snooze input puts the block into a standby state that keeps the stored data. While snoozing, the block turns its drivers off and ignores strobes. After snooze is released, a fixed number of wake cycles must pass before a new access is accepted.

Top module: `sync_burst_sram`

## Requirements
- R1: With `start_c_n` low and the processor strobe not taking effect, a burst opens at `addr`, and the write controls sampled in that same cycle decide between read and write. A write cycle never turns `dq_oe` on in the following cycle.
- R2: `start_p_n` low takes effect only while `sel_n` is low. With `sel_n` high the processor strobe is ignored. If no burst is open and no controller strobe is present, `dq_oe` then stays low.
- R3: The first cycle of a burst opened by the processor strobe is always a read, whatever the write controls are. A write to that word is done on the next cycle, with both strobes high and `adv_n` high.
- R4: In a cycle where either strobe takes effect, the block deselects if `sel_n` is high, `sel_hi` is low or `sel_lo_n` is high. Deselection closes the burst and turns the drivers off. `sel_hi` and `sel_lo_n` have no effect in cycles without a strobe.
- R5: With both strobes high, `adv_n` low and a burst open, the counter steps and the next word is accessed. With `order_xor` = 0 the low two address bits go base+1, base+2, base+3, wrapping modulo 4.
- R6: With `order_xor` = 1 the low two address bits are the base XOR 1, 2 and 3 in turn.
- R7: With both strobes high, `adv_n` high and a burst open, the current word is accessed again.
- R8: `wr_all_n` low writes every lane. Otherwise, `wr_lane_en_n` low writes lane i exactly when `wr_lane_n[i]` is low; lane i covers data bits [i*LANE_W +: LANE_W]. When no lane is selected the access is a read.
- R9: All `LANE_W` bits of a lane, the parity bit at the lane's top position included, are stored and returned unchanged.
- R10: Read data is on `dq_out` with `dq_oe` high from the edge that sampled the read until the next edge. `dq_oe` is low at once whenever `out_en_n` is high.
- R11: At an edge with `snooze` high the drivers turn off and the burst closes, and strobes are ignored while `snooze` is high. After release, two more edges ignore strobes. Stored data is kept.
- R12: After reset no burst is open and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snooze | input | 1 | Standby request, data retained |
| order_xor | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address sampled on a strobe |
| start_p_n | input | 1 | Processor burst-start strobe, active low |
| start_c_n | input | 1 | Controller burst-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary select, active low |
| sel_hi | input | 1 | Secondary select, active high |
| sel_lo_n | input | 1 | Secondary select, active low |
| wr_all_n | input | 1 | Write every lane, active low |
| wr_lane_en_n | input | 1 | Enables per-lane write strobes, active low |
| wr_lane_n | input | LANES | Per-lane write strobes, active low |
| out_en_n | input | 1 | Output enable, active low, not registered |
| dq_in | input | LANES*LANE_W | Write data from the pad |
| dq_out | output | LANES*LANE_W | Registered read data to the pad |
| dq_oe | output | 1 | Pad driver enable |

## Verification
On every cycle the assertions check the following. A masked processor strobe never opens a burst. Deselection and snooze always leave the burst closed and the drivers off. A hold leaves the burst counter unchanged, and an advance moves it by exactly one. A write cycle is never followed by driven data. The bench scenarios are needed for everything that depends on stored contents: the linear and interleaved address orders, the lane masking and parity retention, the delayed write after a processor strobe, and data surviving snooze with the two ignored wake cycles.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_START,
    OP_NEXT,
    OP_HOLD,
    OP_DROP
  } op_e;

  function automatic logic is_access(op_e op);
    return (op == OP_START) || (op == OP_NEXT) || (op == OP_HOLD);
  endfunction
endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
  import sbr_pkg::*;
#(
  parameter int LANES       = 2,
  parameter int WAKE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snooze,
  input  logic             burst_live,
  input  logic             start_p_n,
  input  logic             start_c_n,
  input  logic             adv_n,
  input  logic             sel_n,
  input  logic             sel_hi,
  input  logic             sel_lo_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] wr_lane_n,
  output op_e              op,
  output logic             first_rd,
  output logic [LANES-1:0] lane_we
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);

  logic [CW-1:0]    wake_q;
  logic             proc_hit, ctrl_hit, any_hit, unsel;
  logic [LANES-1:0] lane_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wake_q <= '0;
    else if (snooze)         wake_q <= CW'(WAKE_CYCLES);
    else if (wake_q != '0)   wake_q <= wake_q - CW'(1);
  end

  always_comb begin
    proc_hit = !start_p_n && !sel_n;
    ctrl_hit = !start_c_n;
    any_hit  = proc_hit || ctrl_hit;
    unsel    = sel_n || !sel_hi || sel_lo_n;
    if (snooze)             op = OP_DROP;
    else if (wake_q != '0)  op = OP_IDLE;
    else if (any_hit)       op = unsel ? OP_DROP : OP_START;
    else if (burst_live)    op = adv_n ? OP_HOLD : OP_NEXT;
    else                    op = OP_IDLE;
    first_rd = (op == OP_START) && proc_hit;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_req[i] = !wr_all_n || (!wr_lane_en_n && !wr_lane_n[i]);
  end

  assign lane_we = (is_access(op) && !first_rd) ? lane_req : '0;

  // R2
  masked_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_p_n && start_c_n && sel_n) |-> (op != OP_START));

  // R11
  wake_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(snooze) |-> (op != OP_START));
endmodule

// File: rtl/sbr_seq.sv
module sbr_seq
  import sbr_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              order_xor,
  output logic              burst_live,
  output logic [ADDR_W-1:0] acc_addr
);
  logic [ADDR_W-1:0]     base_q;
  logic [BURST_BITS-1:0] step_q, step_use, low;
  logic                  live_q;

  always_comb begin
    step_use = (op == OP_NEXT) ? step_q + BURST_BITS'(1) : step_q;
    low      = order_xor ? (base_q[BURST_BITS-1:0] ^ step_use)
                         : (base_q[BURST_BITS-1:0] + step_use);
    acc_addr = (op == OP_START) ? addr : {base_q[ADDR_W-1:BURST_BITS], low};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      live_q <= 1'b0;
    end else begin
      case (op)
        OP_START: begin
          base_q <= addr;
          step_q <= '0;
          live_q <= 1'b1;
        end
        OP_NEXT: step_q <= step_q + BURST_BITS'(1);
        OP_DROP: live_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign burst_live = live_q;

  // R4
  drop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DROP) |=> !live_q);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> $stable(step_q));

  // R5
  next_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NEXT) |=> (step_q == BURST_BITS'($past(step_q) + 1'b1)));
endmodule

// File: rtl/sbr_store.sv
module sbr_store #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    drive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic drive_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] q_q;

    always_ff @(posedge clk) begin
      if (lane_we[i]) cells[acc_addr] <= din[i*LANE_W +: LANE_W];
      if (rd_en)      q_q <= cells[acc_addr];
    end

    assign q[i*LANE_W +: LANE_W] = q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= rd_en;
  end

  assign drive = drive_q;

  // R1
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |=> !drive_q);
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbr_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int LANES       = 2,
  parameter int LANE_W      = 9,
  parameter int BURST_BITS  = 2,
  parameter int WAKE_CYCLES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    snooze,
  input  logic                    order_xor,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    start_p_n,
  input  logic                    start_c_n,
  input  logic                    adv_n,
  input  logic                    sel_n,
  input  logic                    sel_hi,
  input  logic                    sel_lo_n,
  input  logic                    wr_all_n,
  input  logic                    wr_lane_en_n,
  input  logic [LANES-1:0]        wr_lane_n,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  op_e               op;
  logic              first_rd, burst_live, rd_en, drive;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] acc_addr;

  sbr_decode #(.LANES(LANES), .WAKE_CYCLES(WAKE_CYCLES)) u_dec (
    .clk(clk), .rst_n(rst_n), .snooze(snooze), .burst_live(burst_live),
    .start_p_n(start_p_n), .start_c_n(start_c_n), .adv_n(adv_n),
    .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .wr_lane_n(wr_lane_n),
    .op(op), .first_rd(first_rd), .lane_we(lane_we)
  );

  sbr_seq #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .op(op), .addr(addr), .order_xor(order_xor),
    .burst_live(burst_live), .acc_addr(acc_addr)
  );

  assign rd_en = is_access(op) && (first_rd || (lane_we == '0));

  sbr_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .lane_we(lane_we),
    .acc_addr(acc_addr), .din(dq_in), .q(dq_out), .drive(drive)
  );

  assign dq_oe = drive && !out_en_n;

  // R11
  snooze_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |=> !dq_oe);

  // R3
  proc_first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_rd |-> (lane_we == '0));
endmodule

// File: tb/sim_sync_burst_sram.sv
`timescale 1ns/1ps
module sim_sync_burst_sram;
  localparam int AW = 10;
  localparam int NL = 2;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snooze = 1'b0, order_xor = 1'b0;
  logic [AW-1:0] addr = '0;
  logic start_p_n = 1'b1, start_c_n = 1'b1, adv_n = 1'b1;
  logic sel_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
  logic wr_all_n = 1'b1, wr_lane_en_n = 1'b1;
  logic [NL-1:0] wr_lane_n = '1;
  logic out_en_n = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_mem [0:(1<<AW)-1];
  logic          m_live = 1'b0, m_drv = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_step = '0;
  int            m_wake = 0;
  logic [DW-1:0] m_q = '0;

  always #2.5 clk = ~clk;

  sync_burst_sram u0 (
    .clk(clk), .rst_n(rst_n), .snooze(snooze), .order_xor(order_xor), .addr(addr),
    .start_p_n(start_p_n), .start_c_n(start_c_n), .adv_n(adv_n),
    .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .wr_lane_n(wr_lane_n),
    .out_en_n(out_en_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 32'h0A5B) ^ 18'h24C31;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  task automatic access(input logic [AW-1:0] a, input bit force_rd);
    logic [NL-1:0] we;
    for (int i = 0; i < NL; i++) we[i] = !wr_all_n || (!wr_lane_en_n && !wr_lane_n[i]);
    if (force_rd || we == '0) begin
      m_q = m_mem[a];
      m_drv = 1'b1;
    end else begin
      for (int i = 0; i < NL; i++)
        if (we[i]) m_mem[a][i*LW +: LW] = dq_in[i*LW +: LW];
      m_drv = 1'b0;
    end
  endtask

  task automatic model_edge();
    bit ph, ch;
    logic [1:0] lo;
    if (snooze) begin
      m_wake = 2; m_live = 1'b0; m_drv = 1'b0;
    end else if (m_wake > 0) begin
      m_wake--; m_drv = 1'b0;
    end else begin
      ph = !start_p_n && !sel_n;
      ch = !start_c_n;
      if (ph || ch) begin
        if (sel_n || !sel_hi || sel_lo_n) begin
          m_live = 1'b0; m_drv = 1'b0;
        end else begin
          m_base = addr; m_step = 2'd0; m_live = 1'b1;
          access(addr, ph);
        end
      end else if (m_live) begin
        if (!adv_n) m_step = m_step + 2'd1;
        lo = order_xor ? (m_base[1:0] ^ m_step) : (m_base[1:0] + m_step);
        access({m_base[AW-1:2], lo}, 1'b0);
      end else begin
        m_drv = 1'b0;
      end
    end
  endtask

  task automatic check_out(input string tag);
    logic exp_oe;
    exp_oe = m_drv && !out_en_n;
    vectors++;
    if (dq_oe !== exp_oe) begin
      misses++;
      $display("FAIL %s: dq_oe=%0b expected %0b", tag, dq_oe, exp_oe);
    end else if (exp_oe) begin
      vectors++;
      if (dq_out !== m_q) begin
        misses++;
        $display("FAIL %s: dq_out=%h expected %h", tag, dq_out, m_q);
      end
    end
  endtask

  task automatic expect_val(input string tag, input logic ex_oe, input logic [DW-1:0] ex_q);
    vectors++;
    if (dq_oe !== ex_oe || (ex_oe && dq_out !== ex_q)) begin
      misses++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", tag, dq_oe, dq_out, ex_oe, ex_q);
    end
  endtask

  task automatic tick(input string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic quiet();
    start_p_n = 1'b1; start_c_n = 1'b1; adv_n = 1'b1;
    sel_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
    wr_all_n = 1'b1; wr_lane_en_n = 1'b1; wr_lane_n = '1;
    out_en_n = 1'b0; snooze = 1'b0;
  endtask

  task automatic ctrl_start(input int a, input bit wr, input string tag);
    quiet(); addr = AW'(a); start_c_n = 1'b0; wr_all_n = !wr;
    tick(tag);
  endtask

  task automatic close_burst();
    quiet(); start_c_n = 1'b0; sel_hi = 1'b0;
    tick("R4");
  endtask

  initial begin
    #200000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < (1<<AW); i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_val("R12", 1'b0, '0);

    // R1: preload with controller-strobe writes
    for (int a = 0; a < 32; a++) begin
      dq_in = pat(a);
      ctrl_start(a, 1'b1, "R1");
    end
    close_burst();

    // R1 / R10: read latency and asynchronous output enable
    ctrl_start(5, 1'b0, "R10");
    expect_val("R10", 1'b1, pat(5));
    out_en_n = 1'b1; #1;
    expect_val("R10", 1'b0, '0);
    out_en_n = 1'b0; #1;
    expect_val("R10", 1'b1, pat(5));

    // R5: linear order from 5 -> 6,7,4
    order_xor = 1'b0;
    ctrl_start(5, 1'b0, "R5");
    for (int k = 0; k < 3; k++) begin quiet(); adv_n = 1'b0; tick("R5"); end
    expect_val("R5", 1'b1, pat(4));
    // R7: suspend repeats word 4
    quiet(); tick("R7");
    expect_val("R7", 1'b1, pat(4));
    // R4: secondary selects ignored without a strobe
    quiet(); adv_n = 1'b0; sel_hi = 1'b0; sel_lo_n = 1'b1; tick("R4");
    expect_val("R4", 1'b1, pat(5));

    // R6: interleaved from 5 -> 4,7,6
    order_xor = 1'b1;
    ctrl_start(5, 1'b0, "R6");
    quiet(); adv_n = 1'b0; tick("R6");
    expect_val("R6", 1'b1, pat(4));
    quiet(); adv_n = 1'b0; tick("R6");
    quiet(); adv_n = 1'b0; tick("R6");
    expect_val("R6", 1'b1, pat(6));
    order_xor = 1'b0;

    // R3: processor start ignores write controls, writes on next cycle
    quiet(); addr = AW'(9); start_p_n = 1'b0; wr_all_n = 1'b0; dq_in = 18'h3FFFF;
    tick("R3");
    expect_val("R3", 1'b1, pat(9));
    quiet(); wr_lane_en_n = 1'b0; wr_lane_n = 2'b10; dq_in = 18'h31234;
    tick("R3");
    ctrl_start(9, 1'b0, "R3");
    expect_val("R3", 1'b1, {pat(9)[17:9], 9'h034});

    // R4: deselect variants
    close_burst();
    quiet(); tick("R4");
    expect_val("R4", 1'b0, '0);
    ctrl_start(2, 1'b0, "R4");
    quiet(); start_c_n = 1'b0; sel_lo_n = 1'b1; tick("R4");
    quiet(); adv_n = 1'b0; tick("R4");
    expect_val("R4", 1'b0, '0);
    quiet(); start_c_n = 1'b0; sel_n = 1'b1; tick("R4");
    expect_val("R4", 1'b0, '0);

    // R2: processor strobe masked by primary select
    quiet(); sel_n = 1'b1; start_p_n = 1'b0; addr = AW'(3); tick("R2");
    expect_val("R2", 1'b0, '0);

    // R8: lane decode
    quiet(); addr = AW'(12); start_c_n = 1'b0; wr_lane_en_n = 1'b0; wr_lane_n = 2'b01;
    dq_in = 18'h155AA; tick("R8");
    quiet(); wr_lane_en_n = 1'b0; wr_lane_n = 2'b11; tick("R8");
    expect_val("R8", 1'b1, {9'h0AA, pat(12)[8:0]});

    // R9: parity bits kept
    dq_in = 18'h20100;
    ctrl_start(13, 1'b1, "R9");
    ctrl_start(13, 1'b0, "R9");
    expect_val("R9", 1'b1, 18'h20100);

    // R11: snooze, ignored strobes, wake cycles, retention
    ctrl_start(20, 1'b0, "R11");
    quiet(); snooze = 1'b1; tick("R11");
    expect_val("R11", 1'b0, '0);
    quiet(); snooze = 1'b1; addr = AW'(21); start_c_n = 1'b0; wr_all_n = 1'b0; dq_in = '0;
    tick("R11");
    ctrl_start(20, 1'b0, "R11");
    expect_val("R11", 1'b0, '0);
    ctrl_start(20, 1'b0, "R11");
    expect_val("R11", 1'b0, '0);
    ctrl_start(21, 1'b0, "R11");
    expect_val("R11", 1'b1, pat(21));

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if (n % 200 == 0) order_xor = 1'($urandom_range(0, 1));
      addr         = AW'($urandom_range(0, 31));
      start_c_n    = ($urandom_range(0, 7) != 0);
      start_p_n    = ($urandom_range(0, 7) != 0);
      sel_n        = ($urandom_range(0, 7) == 0);
      sel_hi       = ($urandom_range(0, 15) != 0);
      sel_lo_n     = ($urandom_range(0, 15) == 0);
      adv_n        = 1'($urandom_range(0, 1));
      wr_all_n     = ($urandom_range(0, 7) != 0);
      wr_lane_en_n = 1'($urandom_range(0, 1));
      wr_lane_n    = NL'($urandom_range(0, 3));
      out_en_n     = ($urandom_range(0, 7) == 0);
      snooze       = ($urandom_range(0, 63) == 0);
      dq_in        = DW'($urandom);
      tick("R1 R5 R6 R7 R8");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule